// File: doc/BRIEF.md
# Reverse-Polish Stack Execution Unit

This block runs instructions for a zero-operand machine. All operands live on an on-chip stack of `DEPTH` words, each `W` bits wide. A count register tracks how many entries are in use. Each instruction is a 4-bit opcode with an optional literal. It is offered with a valid/ready handshake and takes effect on the clock edge where both are high. Memory is addressed by word, not by byte. It is reached through a single port, `AW` bits wide, with a synchronous read: the block drives the address, write data and write enable, and the read word comes back one edge later.

Addresses for memory access come from the stack itself. A load swaps the top entry for the memory word at the address that entry holds. A store writes the top entry to the address held one slot below it, then drops both entries. Arithmetic and logic operations use the entry below the top as the left operand and the top entry as the right operand. The result replaces both. Two reversed forms swap the operands of subtract and divide.

Faults are reported on three flags, each a one-cycle pulse: overflow, underflow and divide-by-zero. A rejected instruction leaves the stack exactly as it was. The top entry and the entry count are visible at the ports.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset the entry count is 0, `instr_ready` is 1, `tos_o` is 0, `mem_we` is 0 and all three error flags are 0.
- R2: Opcode 0 (push) with fewer than `DEPTH` entries accepts `instr_lit` as the new top entry and raises the count by one.
- R3: A push while the count equals `DEPTH` sets `err_ovf` for the one cycle after acceptance and leaves the count and the top entry unchanged.
- R4: Opcode 1 (load) with at least one entry drives `mem_addr` with the low `AW` bits of the top entry in the acceptance cycle. It holds `instr_ready` low for exactly the next cycle, then replaces the top entry with the returned word. The count is unchanged.
- R5: Opcode 2 (store) with at least two entries asserts `mem_we` in the acceptance cycle. It writes the top entry to the address held in the low `AW` bits of the entry below it, and lowers the count by two.
- R6: Binary opcodes combine left = entry below top with right = top entry. They write the result in place of both entries and lower the count by one. The opcodes are 3 add, 4 subtract (left-right), 6 multiply (low `W` bits), 9 AND and 10 OR.
- R7: Opcode 5 (reversed subtract) yields top minus next. Opcode 8 (reversed divide) yields top divided by next.
- R8: Opcode 7 (divide) yields the unsigned quotient of next divided by top, truncated.
- R9: A divide or reversed divide whose divisor is zero writes 0 as the result. It still lowers the count by one and sets `err_dz` for the one cycle after acceptance.
- R10: Opcode 11 (compare) replaces both operands with 1 if they are equal and 0 otherwise, lowering the count by one.
- R11: An instruction needing more entries than are present sets `err_unf` for one cycle and leaves the stack unchanged, with no memory write. Load needs one entry; store and binary opcodes need two.
- R12: Opcodes 12 to 15 are accepted and change neither the stack nor memory, and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_op | input | 4 | Opcode |
| instr_lit | input | W | Literal for push |
| mem_addr | output | AW | Data memory word address |
| mem_wdata | output | W | Data memory write word |
| mem_we | output | 1 | Data memory write enable |
| mem_rdata | input | W | Data memory read word, one edge after the address |
| tos_o | output | W | Current top entry, 0 when empty |
| depth_o | output | $clog2(DEPTH+1) | Current entry count |
| err_ovf | output | 1 | Push on a full stack |
| err_unf | output | 1 | Too few entries for the opcode |
| err_dz | output | 1 | Division by zero |

## Verification
The hardest state to reach from the ports is a full stack. Every push costs a handshake, and stores and binary operations keep draining the stack. A directed phase therefore empties the stack, pushes exactly `DEPTH` literals, and then offers one more push and an undefined opcode. Zero divisors on both sides of both divide forms rarely occur with full-width random literals. The random phase draws most literals from a tiny range, so zeros, equal compare operands and aliasing load/store addresses occur often.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam logic [3:0] OP_PUSH  = 4'd0;
  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_STORE = 4'd2;
  localparam logic [3:0] OP_ADD   = 4'd3;
  localparam logic [3:0] OP_SUB   = 4'd4;
  localparam logic [3:0] OP_RSUB  = 4'd5;
  localparam logic [3:0] OP_MUL   = 4'd6;
  localparam logic [3:0] OP_DIV   = 4'd7;
  localparam logic [3:0] OP_RDIV  = 4'd8;
  localparam logic [3:0] OP_AND   = 4'd9;
  localparam logic [3:0] OP_OR    = 4'd10;
  localparam logic [3:0] OP_CMP   = 4'd11;

  typedef enum logic {ST_RUN, ST_LOAD} stk_state_e;

  function automatic logic op_is_binary(input logic [3:0] op);
    return (op >= OP_ADD) && (op <= OP_CMP);
  endfunction
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res,
  output logic         div_zero
);
  always_comb begin
    res      = '0;
    div_zero = 1'b0;
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_RSUB: res = rhs - lhs;
      OP_MUL:  res = lhs * rhs;
      OP_DIV: begin
        if (rhs == '0) div_zero = 1'b1;
        else           res = lhs / rhs;
      end
      OP_RDIV: begin
        if (lhs == '0) div_zero = 1'b1;
        else           res = rhs / lhs;
      end
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_CMP:  res = {{(W-1){1'b0}}, (lhs == rhs)};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slot_q[waddr] <= wdata;
  end

  assign rdata_a = slot_q[raddr_a];
  assign rdata_b = slot_q[raddr_b];
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
  import stk_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [3:0]    instr_op,
  input  logic [W-1:0]  instr_lit,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          mem_we,
  input  logic [W-1:0]  mem_rdata,
  output logic [W-1:0]  tos_o,
  output logic [CW-1:0] depth_o,
  output logic          err_ovf,
  output logic          err_unf,
  output logic          err_dz
);
  stk_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] top_idx, nxt_idx;
  logic [W-1:0]  top_val, nxt_val, alu_res;
  logic          alu_dz;
  logic          fire, is_bin, unf_c, ovf_c, ok_c;
  logic [CW-1:0] need_c;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_data;
  logic          err_ovf_q, err_unf_q, err_dz_q;

  assign top_idx = IW'(cnt_q - CW'(1));
  assign nxt_idx = IW'(cnt_q - CW'(2));

  stk_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_idx),
    .wdata   (wr_data),
    .raddr_a (top_idx),
    .rdata_a (top_val),
    .raddr_b (nxt_idx),
    .rdata_b (nxt_val)
  );

  stk_alu #(.W(W)) u_alu (
    .op       (instr_op),
    .lhs      (nxt_val),
    .rhs      (top_val),
    .res      (alu_res),
    .div_zero (alu_dz)
  );

  assign instr_ready = (state_q == ST_RUN);
  assign fire        = instr_valid && instr_ready;
  assign is_bin      = op_is_binary(instr_op);

  always_comb begin
    need_c = '0;
    if (instr_op == OP_LOAD)                     need_c = CW'(1);
    else if (instr_op == OP_STORE || is_bin)     need_c = CW'(2);
  end

  assign unf_c = fire && (cnt_q < need_c);
  assign ovf_c = fire && (instr_op == OP_PUSH) && (cnt_q == CW'(DEPTH));
  assign ok_c  = fire && !unf_c && !ovf_c;

  // memory port: load reads at the acceptance edge, store writes there
  assign mem_we    = ok_c && (instr_op == OP_STORE);
  assign mem_addr  = (instr_op == OP_STORE) ? nxt_val[AW-1:0] : top_val[AW-1:0];
  assign mem_wdata = top_val;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = top_idx;
    wr_data = mem_rdata;
    if (state_q == ST_LOAD) begin
      wr_en = 1'b1;
    end else if (ok_c && instr_op == OP_PUSH) begin
      wr_en   = 1'b1;
      wr_idx  = cnt_q[IW-1:0];
      wr_data = instr_lit;
    end else if (ok_c && is_bin) begin
      wr_en   = 1'b1;
      wr_idx  = nxt_idx;
      wr_data = alu_res;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      cnt_q     <= '0;
      err_ovf_q <= 1'b0;
      err_unf_q <= 1'b0;
      err_dz_q  <= 1'b0;
    end else begin
      err_ovf_q <= ovf_c;
      err_unf_q <= unf_c;
      err_dz_q  <= ok_c && is_bin && alu_dz;
      if (state_q == ST_LOAD) begin
        state_q <= ST_RUN;
      end else if (ok_c) begin
        if (instr_op == OP_LOAD)       state_q <= ST_LOAD;
        if (instr_op == OP_PUSH)       cnt_q   <= cnt_q + CW'(1);
        else if (instr_op == OP_STORE) cnt_q   <= cnt_q - CW'(2);
        else if (is_bin)               cnt_q   <= cnt_q - CW'(1);
      end
    end
  end

  assign tos_o   = (cnt_q == '0) ? '0 : top_val;
  assign depth_o = cnt_q;
  assign err_ovf = err_ovf_q;
  assign err_unf = err_unf_q;
  assign err_dz  = err_dz_q;
endmodule

// File: rtl/stk_exec_sva.sv
module stk_exec_sva #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          instr_valid,
  input logic          instr_ready,
  input logic [3:0]    instr_op,
  input logic [W-1:0]  instr_lit,
  input logic          mem_we,
  input logic [W-1:0]  tos_o,
  input logic [CW-1:0] depth_o,
  input logic          err_ovf,
  input logic          err_unf,
  input logic          err_dz
);
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_ready && instr_op == 4'd0 && depth_o != CW'(DEPTH))
    |=> (depth_o == $past(depth_o) + CW'(1)) && (tos_o == $past(instr_lit)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    depth_o <= CW'(DEPTH));

  assert_ovf_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    err_ovf |-> $stable(depth_o));

  assert_load_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_ready && instr_op == 4'd1 && depth_o != '0) |=> !instr_ready);

  assert_store_pops_R5: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_ready && instr_op == 4'd2 && depth_o >= CW'(2))
    |=> depth_o == $past(depth_o) - CW'(2));

  assert_we_guarded_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (instr_valid && instr_ready && instr_op == 4'd2 && depth_o >= CW'(2)));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_ovf, err_unf, err_dz}));
endmodule

bind stk_exec_unit stk_exec_sva #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_sva (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .instr_op(instr_op), .instr_lit(instr_lit), .mem_we(mem_we), .tos_o(tos_o),
  .depth_o(depth_o), .err_ovf(err_ovf), .err_unf(err_unf), .err_dz(err_dz)
);

// File: tb/stk_exec_unit_bench.sv
module stk_exec_unit_bench;
  localparam int W = 16, DEPTH = 16, AW = 8, CW = $clog2(DEPTH + 1);
  localparam int MW = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, instr_valid, instr_ready, mem_we, err_ovf, err_unf, err_dz;
  logic [3:0]    instr_op;
  logic [W-1:0]  instr_lit, mem_wdata, mem_rdata, tos_o;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] depth_o;

  stk_exec_unit #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_stk_exec_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_lit(instr_lit), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata), .tos_o(tos_o),
    .depth_o(depth_o), .err_ovf(err_ovf), .err_unf(err_unf), .err_dz(err_dz)
  );

  // synchronous word memory, preloaded during reset
  logic [W-1:0] dmem [MW];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MW; i++) dmem[i] <= W'(i * 37 + 5);
      mem_rdata <= '0;
    end else begin
      if (mem_we) dmem[mem_addr] <= mem_wdata;
      mem_rdata <= dmem[mem_addr];
    end
  end

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int m_cnt = 0;
  logic [W-1:0] m_stk [DEPTH];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_alu(input logic [3:0] op, input logic [W-1:0] n,
                                           input logic [W-1:0] t, output bit dz);
    dz = 1'b0;
    case (op)
      4'd3:  return n + t;
      4'd4:  return n - t;
      4'd5:  return t - n;
      4'd6:  return W'(n * t);
      4'd7:  begin if (t == 0) begin dz = 1'b1; return '0; end return n / t; end
      4'd8:  begin if (n == 0) begin dz = 1'b1; return '0; end return t / n; end
      4'd9:  return n & t;
      4'd10: return n | t;
      4'd11: return (n == t) ? W'(1) : W'(0);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op, input bit dz);
    if (dz) return "R9";
    case (op)
      4'd0: return "R2";  4'd1: return "R4";  4'd2: return "R5";
      4'd5, 4'd8: return "R7";
      4'd7: return "R8";
      4'd11: return "R10";
      4'd3, 4'd4, 4'd6, 4'd9, 4'd10: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic do_op(input logic [3:0] op, input logic [W-1:0] lit);
    logic [W-1:0] t, n, r;
    bit dz, e_ovf, e_unf, is_bin;
    int need;
    string tag;
    t = (m_cnt >= 1) ? m_stk[m_cnt-1] : '0;
    n = (m_cnt >= 2) ? m_stk[m_cnt-2] : '0;
    is_bin = (op >= 4'd3 && op <= 4'd11);
    need = (op == 4'd1) ? 1 : ((op == 4'd2 || is_bin) ? 2 : 0);
    e_unf = (m_cnt < need);
    e_ovf = (op == 4'd0) && (m_cnt == DEPTH);
    r = exp_alu(op, n, t, dz);
    if (!is_bin || e_unf) dz = 1'b0;
    tag = e_unf ? "R11" : (e_ovf ? "R3" : tag_of(op, dz));
    @(negedge clk);
    instr_valid = 1'b1; instr_op = op; instr_lit = lit;
    #1;
    if (op == 4'd2 && !e_unf) begin
      chk(mem_we === 1'b1, "R5", "mem_we", mem_we, 1);
      chk(mem_addr === n[AW-1:0], "R5", "mem_addr", mem_addr, n[AW-1:0]);
      chk(mem_wdata === t, "R5", "mem_wdata", mem_wdata, t);
    end else begin
      chk(mem_we === 1'b0, tag, "mem_we idle", mem_we, 0);
    end
    if (op == 4'd1 && !e_unf) begin
      chk(mem_addr === t[AW-1:0], "R4", "load addr", mem_addr, t[AW-1:0]);
      r = dmem[t[AW-1:0]];
    end
    @(posedge clk); #1;
    instr_valid = 1'b0;
    @(negedge clk);
    if (op == 4'd1 && !e_unf) begin
      chk(instr_ready === 1'b0, "R4", "ready during load", instr_ready, 0);
      chk(err_ovf === 0 && err_unf === 0 && err_dz === 0, "R4", "flags", 
          {err_ovf, err_unf, err_dz}, 0);
      @(negedge clk);
      chk(instr_ready === 1'b1, "R4", "ready after load", instr_ready, 1);
    end else begin
      chk(err_ovf === e_ovf, tag, "err_ovf", err_ovf, e_ovf);
      chk(err_unf === e_unf, tag, "err_unf", err_unf, e_unf);
      chk(err_dz === dz, tag, "err_dz", err_dz, dz);
    end
    if (!e_unf && !e_ovf) begin
      if (op == 4'd0) begin m_stk[m_cnt] = lit; m_cnt++; end
      else if (op == 4'd1) m_stk[m_cnt-1] = r;
      else if (op == 4'd2) begin
        m_cnt -= 2;
        chk(dmem[n[AW-1:0]] === t, "R5", "stored word", dmem[n[AW-1:0]], t);
      end else if (is_bin) begin m_stk[m_cnt-2] = r; m_cnt--; end
    end
    chk(depth_o == CW'(m_cnt), tag, "depth", depth_o, m_cnt);
    if (m_cnt > 0) chk(tos_o === m_stk[m_cnt-1], tag, "top", tos_o, m_stk[m_cnt-1]);
  endtask

  task automatic drain();
    if (m_cnt == 1) do_op(4'd0, W'(200));
    while (m_cnt >= 2) do_op(4'd2, '0);
  endtask

  task automatic pair(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    drain();
    do_op(4'd0, a);
    do_op(4'd0, b);
    do_op(op, '0);
  endtask

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr_op = '0; instr_lit = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(depth_o == 0, "R1", "depth", depth_o, 0);
    chk(instr_ready === 1'b1, "R1", "ready", instr_ready, 1);
    chk(tos_o === '0, "R1", "tos", tos_o, 0);
    chk(mem_we === 1'b0, "R1", "mem_we", mem_we, 0);
    chk({err_ovf, err_unf, err_dz} === 3'b0, "R1", "flags", {err_ovf, err_unf, err_dz}, 0);

    // R11: underflow cases
    do_op(4'd3, '0);
    do_op(4'd1, '0);
    do_op(4'd0, W'(9));
    do_op(4'd2, '0);
    do_op(4'd11, '0);

    // R6 / R7 / R8 / R9 / R10 directed pairs
    pair(4'd3, W'(1000), W'(234));
    pair(4'd4, W'(5), W'(3));
    pair(4'd4, W'(3), W'(5));
    pair(4'd5, W'(3), W'(5));
    pair(4'd6, W'(300), W'(300));
    pair(4'd9, W'(16'hF0F0), W'(16'h3C3C));
    pair(4'd10, W'(16'hF0F0), W'(16'h0F01));
    pair(4'd7, W'(20), W'(6));
    pair(4'd8, W'(6), W'(20));
    pair(4'd7, W'(9), W'(0));
    pair(4'd8, W'(0), W'(9));
    pair(4'd11, W'(7), W'(7));
    pair(4'd11, W'(7), W'(8));

    // R4 / R5: load from preload, store then reload
    drain();
    do_op(4'd0, W'(40));
    do_op(4'd1, '0);
    do_op(4'd0, W'(100));
    do_op(4'd0, W'(16'hBEEF));
    do_op(4'd2, '0);
    do_op(4'd0, W'(100));
    do_op(4'd1, '0);

    // R3: fill to full, then overflow; R12: undefined opcodes at full
    drain();
    while (m_cnt > 0) do_op(4'd3, '0);
    for (int i = 0; i < DEPTH; i++) do_op(4'd0, W'(i + 50));
    do_op(4'd0, W'(999));
    do_op(4'd13, W'(1));
    do_op(4'd15, W'(2));

    // random mix, small literals to hit zero divisors and aliasing
    void'($urandom(32'd4242));
    for (int k = 0; k < 600; k++) begin
      logic [3:0] op;
      logic [W-1:0] lit;
      op  = 4'($urandom % 14);
      if (op == 4'd13) op = 4'd0;
      lit = ($urandom % 4 != 0) ? W'($urandom % 6) : W'($urandom);
      do_op(op, lit);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule